// File: doc/BRIEF.md
# Memory Region Security Filter

This block sits beside a memory-request path and labels every request address as either reserved for secure masters or open to all. Firmware programs up to eight address windows in one-megabyte steps, chooses which windows are protected, and can also protect all memory that lies outside every window. A global bypass bit turns all protection off. At reset the bypass is set, so nothing is protected until firmware configures the block.

The block registers its result. One cycle after a request is presented, it returns a response with the secure-only classification. If a non-secure master touches a protected address, the response also carries a violation flag, and a sticky status bit latches the event until software clears it. Secure masters are never flagged. Blocking the access and producing an error response are left to the surrounding fabric.

Top module: `mem_region_guard`

## Requirements
- R1: After reset, every boundary field reads 0, the control register reads 0x200 (bypass set, all enables clear), the status register reads 0, and every request is classified as not secure-only.
- R2: Register index n (0..7) holds the start megabyte of window n and index n+8 holds its end megabyte, each in bits [11:0]. Index 16 is control: bits [7:0] are the per-window enables, bit 8 is the outside-all-windows enable and bit 9 is the bypass. Index 17 is status, with bit 0 sticky. Reads return the field zero-extended to 32 bits.
- R3: A write changes a low-half bit k only when write-data bit k+16 is set. Bits with a clear mask keep their value.
- R4: An address matches window n when start_n <= addr[31:20] <= end_n, with both ends inclusive. A window whose start is above its end matches nothing.
- R5: An address inside any enabled window is secure-only. Overlapping windows combine by OR.
- R6: When control bit 8 is set, an address that lies in none of the eight windows is secure-only. This applies whether those windows are enabled or not. An address inside a disabled window is not made secure-only by bit 8.
- R7: When control bit 9 is set, every address is classified as not secure-only and no violation is raised, whatever the other bits hold.
- R8: A request sampled with req_valid high produces rsp_valid high for exactly the next cycle, carrying its classification. When rsp_valid is low, rsp_secure_only and rsp_violation are 0.
- R9: rsp_violation is 1 exactly when the request came from a non-secure master (req_secure = 0) and its address was secure-only. A secure master is never flagged.
- R10: The status bit is set in the same cycle that rsp_violation rises. It is cleared by a write to index 17 with data bits 0 and 16 both set. If a violation and a clear arrive together, the violation wins.
- R11: Writes to register indices 18..31 change nothing, and reads of those indices return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_idx | input | 5 | Register index |
| cfg_wdata | input | 32 | Write data: mask in bits [31:16], value in bits [15:0] |
| cfg_rdata | output | 32 | Combinational read data for cfg_idx |
| req_valid | input | 1 | Request present |
| req_addr | input | 32 | Request byte address |
| req_secure | input | 1 | 1 when the requesting master is secure |
| rsp_valid | output | 1 | Classification valid, one cycle after the request |
| rsp_secure_only | output | 1 | The address is reserved for secure masters |
| rsp_violation | output | 1 | A non-secure master hit a secure-only address |
| viol_sticky | output | 1 | Latched violation status |

## Verification
The embedded assertions check properties that must hold on every cycle:
- A response appears only after a request.
- A violation always comes with a secure-only response.
- A secure master is never flagged.
- A response taken while bypass was set is never secure-only.
- The sticky bit is set whenever a violation is reported.

Only the bench scenarios can show the following:
- The inclusive window edges and the empty inverted window.
- The way disabled windows carve holes out of the outside-all-windows rule.
- The masked-write behaviour.
- The priority of a violation over a clear that arrives in the same cycle.

// File: rtl/mem_region_guard.sv
module mem_region_guard #(
  parameter int ADDR_W = 32,
  parameter int GRAIN  = 20,
  parameter int NRGN   = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [4:0]  cfg_idx,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic        req_valid,
  input  logic [31:0] req_addr,
  input  logic        req_secure,
  output logic        rsp_valid,
  output logic        rsp_secure_only,
  output logic        rsp_violation,
  output logic        viol_sticky
);
  localparam int MB_W    = ADDR_W - GRAIN;
  localparam int CTL_W   = NRGN + 2;
  localparam int CTL_IDX = 2 * NRGN;
  localparam int STS_IDX = 2 * NRGN + 1;
  localparam int REM_BIT = NRGN;
  localparam int BYP_BIT = NRGN + 1;

  logic [MB_W-1:0]  st_q [NRGN];
  logic [MB_W-1:0]  ed_q [NRGN];
  logic [CTL_W-1:0] ctl_q;
  logic [NRGN-1:0]  hit;

  wire [MB_W-1:0]  mb_idx = req_addr[ADDR_W-1:GRAIN];
  wire [MB_W-1:0]  mb_msk = cfg_wdata[16 +: MB_W];
  wire [CTL_W-1:0] ct_msk = cfg_wdata[16 +: CTL_W];
  wire [NRGN-1:0]  en     = ctl_q[NRGN-1:0];
  wire             bypass = ctl_q[BYP_BIT];
  wire             sec_now = !bypass && ((|(hit & en)) || (ctl_q[REM_BIT] && !(|hit)));
  wire             viol_now = req_valid && !req_secure && sec_now;
  wire             clr_req = cfg_we && (cfg_idx == 5'(STS_IDX)) && cfg_wdata[0] && cfg_wdata[16];

  for (genvar i = 0; i < NRGN; i++) begin : g_rgn
    assign hit[i] = (mb_idx >= st_q[i]) && (mb_idx <= ed_q[i]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_q[i] <= '0;
        ed_q[i] <= '0;
      end else if (cfg_we) begin
        if (cfg_idx == 5'(i))
          st_q[i] <= (st_q[i] & ~mb_msk) | (cfg_wdata[MB_W-1:0] & mb_msk);
        if (cfg_idx == 5'(i + NRGN))
          ed_q[i] <= (ed_q[i] & ~mb_msk) | (cfg_wdata[MB_W-1:0] & mb_msk);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q           <= CTL_W'(1) << BYP_BIT;
      rsp_valid       <= 1'b0;
      rsp_secure_only <= 1'b0;
      rsp_violation   <= 1'b0;
      viol_sticky     <= 1'b0;
    end else begin
      if (cfg_we && cfg_idx == 5'(CTL_IDX))
        ctl_q <= (ctl_q & ~ct_msk) | (cfg_wdata[CTL_W-1:0] & ct_msk);
      rsp_valid       <= req_valid;
      rsp_secure_only <= req_valid && sec_now;
      rsp_violation   <= viol_now;
      if (viol_now)     viol_sticky <= 1'b1;
      else if (clr_req) viol_sticky <= 1'b0;
    end
  end

  always_comb begin
    cfg_rdata = '0;
    for (int i = 0; i < NRGN; i++) begin
      if (cfg_idx == 5'(i))        cfg_rdata = 32'(st_q[i]);
      if (cfg_idx == 5'(i + NRGN)) cfg_rdata = 32'(ed_q[i]);
    end
    if (cfg_idx == 5'(CTL_IDX)) cfg_rdata = 32'(ctl_q);
    if (cfg_idx == 5'(STS_IDX)) cfg_rdata = 32'(viol_sticky);
  end

  // R8
  rsp_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid));

  // R9
  viol_needs_secure_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_violation |-> (rsp_valid && rsp_secure_only));

  // R9
  secure_master_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(req_secure)) |-> !rsp_violation);

  // R7
  bypass_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(bypass)) |-> !rsp_secure_only);

  // R10
  sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_violation |-> viol_sticky);
endmodule

// File: tb/sim_mem_region_guard.sv
module sim_mem_region_guard;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, req_valid = 0, req_secure = 0;
  logic [4:0] cfg_idx = 0;
  logic [31:0] cfg_wdata = 0, req_addr = 0;
  logic [31:0] cfg_rdata;
  logic rsp_valid, rsp_secure_only, rsp_violation, viol_sticky;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  mem_region_guard u0 (.*);

  // {address, secure master, expected secure-only, expected violation}
  localparam logic [34:0] VEC [0:9] = '{
    {32'h0000_0000, 1'b0, 1'b1, 1'b1},
    {32'h01F0_0000, 1'b0, 1'b1, 1'b1},
    {32'h0FA0_0000, 1'b0, 1'b0, 1'b0},
    {32'h0640_0000, 1'b1, 1'b1, 1'b0},
    {32'h0650_0000, 1'b0, 1'b1, 1'b1},
    {32'h0C80_0000, 1'b0, 1'b0, 1'b0},
    {32'h12C0_0000, 1'b0, 1'b0, 1'b0},
    {32'h12D0_0000, 1'b1, 1'b1, 1'b0},
    {32'h02D0_0000, 1'b0, 1'b1, 1'b1},
    {32'h0200_0000, 1'b0, 1'b1, 1'b1}
  };

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(int idx, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_idx = 5'(idx); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic rd(string tag, int idx, logic [31:0] exp);
    @(negedge clk);
    cfg_idx = 5'(idx);
    #1 chk(tag, cfg_rdata, exp);
  endtask

  task automatic rq(string tag, logic [31:0] a, logic s, logic es, logic ev);
    @(negedge clk);
    req_valid = 1; req_addr = a; req_secure = s;
    @(negedge clk);
    req_valid = 0;
    chk({tag, " valid"}, 32'(rsp_valid), 1);
    chk({tag, " secure"}, 32'(rsp_secure_only), 32'(es));
    chk({tag, " violation"}, 32'(rsp_violation), 32'(ev));
    @(negedge clk);
    chk({tag, " R8 idle"}, {29'd0, rsp_valid, rsp_secure_only, rsp_violation}, 0);
  endtask

  initial begin
    #40000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    for (int i = 0; i < 16; i++) rd("R1 boundary", i, 0);
    rd("R1 control", 16, 32'h200);
    rd("R1 status", 17, 0);
    rq("R1 req", 32'h0000_0000, 0, 0, 0);
    // R2 R3 program windows
    wr(0, 32'h0FFF_0000);
    wr(8, 32'h0FFF_001F);
    wr(1, 32'h0FFF_0064);  wr(9, 32'h0FFF_0064);
    wr(2, 32'h0FFF_00C8);  wr(10, 32'h0FFF_012C);
    wr(3, 32'h0FFF_0032);  wr(11, 32'h0FFF_0028);
    rd("R2 end0", 8, 32'h1F);
    rd("R2 start2", 2, 32'hC8);
    wr(16, 32'h03FF_010B);
    rd("R2 control", 16, 32'h10B);
    // R4 R5 R6 table
    for (int v = 0; v < 10; v++)
      rq($sformatf("R4 R5 R6 R9 vec%0d", v), VEC[v][34:3], VEC[v][2], VEC[v][1], VEC[v][0]);
    // R10 sticky and clear
    rd("R10 sticky", 17, 1);
    wr(17, 32'h0001_0001);
    rd("R10 cleared", 17, 0);
    wr(17, 32'h0000_0001);
    rq("R10 set", 32'h0, 0, 1, 1);
    wr(17, 32'h0000_0001);
    rd("R3 R10 unmasked clear ignored", 17, 1);
    wr(17, 32'h0001_0001);
    // R10 violation wins over clear
    @(negedge clk);
    cfg_we = 1; cfg_idx = 17; cfg_wdata = 32'h0001_0001;
    req_valid = 1; req_addr = 0; req_secure = 0;
    @(negedge clk);
    cfg_we = 0; req_valid = 0;
    rd("R10 set wins", 17, 1);
    // R6 remainder off
    wr(16, 32'h0100_0000);
    rq("R6 rem off", 32'h0200_0000, 0, 0, 0);
    rq("R5 still", 32'h0000_0000, 0, 1, 1);
    // R3 masked write touches only bypass
    wr(16, 32'h0200_03FF);
    rd("R3 mask", 16, 32'h20B);
    // R7 bypass
    rq("R7 bypass", 32'h0000_0000, 0, 0, 0);
    rq("R7 bypass sec", 32'h0640_0000, 1, 0, 0);
    // R11 unused index
    wr(31, 32'hFFFF_FFFF);
    rd("R11 read", 31, 0);
    rd("R11 ctl kept", 16, 32'h20B);
    rd("R11 start0 kept", 0, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule